// File: doc/BRIEF.md
# SD Card Command Line Engine

This block carries one SD/MMC command at a time on the single-bit CMD line. A host writes a command argument and a command register that holds an index, response options and a go bit. The engine builds the 48-bit command token with its CRC7 and shifts it out, one bit per card-clock enable. If a response is expected, it then waits for the card's reply, collects a short (48-bit) or long (136-bit) response, checks the short response's CRC and raises sticky status flags.

Software polls a busy bit until the exchange is over. It then reads the response words and the echoed response index, writes zero to the command register to park the engine, and clears the flags it has handled through a write-one-to-clear input. The data path, the card clock divider and the card bring-up sequence all sit outside this block.

Top module: `sd_cmd_engine`

## Requirements
- R1: After reset the status is zero, the CMD line is released (`cmd_oe_o`=0) with `cmd_o`=1, and the response words and response index are zero.
- R2: Command register fields are: index in bits [5:0], response expected in bit 6, long response in bit 7, CRC check skip in bit 8, go in bit 10. A write with bit 10 set while idle starts an exchange. Status bit 11 (busy) reads 1 from the clock after that write until the exchange ends.
- R3: The token is 48 bits sent MSB first, one bit per `card_ce_i`: 0, 1, index, argument, CRC7 (x^7+x^3+1 over the first 40 bits), 1. `cmd_oe_o` is high for exactly those 48 bits.
- R4: Without the response-expected bit, the end of the token sets status bit 7 (sent) and clears busy. No other flag is set.
- R5: A short response is a 0 start bit followed by 47 more bits. Its 32 payload bits go to `resp0_o` and its 6-bit index field goes to `resp_idx_o`. A matching CRC7 sets status bit 6 (response done).
- R6: A short response whose CRC7 does not match sets status bit 0 (CRC fail) and not bit 6. When bit 8 was set in the command, the CRC is not compared and bit 6 is set.
- R7: A long response is 136 bits. Its 127 content bits fill `resp0_o`..`resp3_o` from the most significant bit, with `resp3_o[0]`=0. Its 6-bit field after the two lead bits goes to `resp_idx_o`. CRC is never compared and bit 6 is set.
- R8: After the token, the engine samples CMD on each card-clock enable. A start bit on any of the first 64 samples is accepted. 64 high samples in a row set status bit 2 (timeout) and end the exchange. Response error means bit 0 or bit 2.
- R9: Flags in status bits [10:0] are sticky across exchanges. Writing ones on `clr_wdata_i` clears exactly the matching flags.
- R10: A command write with bit 10 clear while busy aborts the exchange. The line is released and busy drops on the next clock, and no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| card_ce_i | input | 1 | One-cycle pulse per card clock period |
| cmd_we_i | input | 1 | Command register write strobe |
| cmd_wdata_i | input | 11 | Command register write value |
| arg_i | input | 32 | Command argument (zero when unused) |
| clr_we_i | input | 1 | Clear register write strobe |
| clr_wdata_i | input | 11 | Ones clear matching status flags |
| cmd_i | input | 1 | CMD line as seen from the card |
| cmd_o | output | 1 | CMD line drive value |
| cmd_oe_o | output | 1 | CMD line drive enable |
| status_o | output | 12 | Flags [10:0], busy in bit 11 |
| resp_idx_o | output | 6 | Index field of the last response |
| resp0_o | output | 32 | Response word 0 |
| resp1_o | output | 32 | Response word 1 |
| resp2_o | output | 32 | Response word 2 |
| resp3_o | output | 32 | Response word 3 |

## Verification
The bench captures every token from the line and compares it with a token it builds itself. One of these is the well-known zero-index token ending in 0x95, so a wrong CRC polynomial or bit order shows up as a frame mismatch. The reply window is probed on both sides of its edge: a start bit on the 64th sample must complete, and one a sample later must time out. An off-by-one counter swaps the two outcomes. Corrupted and reserved CRC fields, a long reply with arbitrary content, sticky flags with partial clears, and an abort in the middle of a token cover a response unpacked into the wrong bits, a check that ignores the skip bit, a clear that wipes too much, and an abort that leaves the line driven.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
  localparam int ARG_W     = 32;
  localparam int IDX_W     = 6;
  localparam int CRC_W     = 7;
  localparam int CRC_SPAN  = 2 + IDX_W + ARG_W;
  localparam int SHORT_W   = CRC_SPAN + CRC_W + 1;
  localparam int LONG_W    = 136;
  localparam int CMD_REG_W = 11;
  localparam int FLAG_W    = 11;

  localparam int CMD_RESP_BIT  = 6;
  localparam int CMD_LONG_BIT  = 7;
  localparam int CMD_NOCRC_BIT = 8;
  localparam int CMD_EN_BIT    = 10;

  localparam int FL_CRC_FAIL = 0;
  localparam int FL_TIMEOUT  = 2;
  localparam int FL_RESP_END = 6;
  localparam int FL_SENT     = 7;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_SEND,
    ENG_RECV
  } eng_state_e;

  function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = b ^ c[CRC_W-1];
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

  function automatic logic [CRC_W-1:0] crc7_calc(input logic [CRC_SPAN-1:0] d);
    logic [CRC_W-1:0] c;
    c = '0;
    for (int i = CRC_SPAN - 1; i >= 0; i--) c = crc7_step(c, d[i]);
    return c;
  endfunction
endpackage

// File: rtl/sd_cmd_tx.sv
module sd_cmd_tx #(
  parameter int FRAME_W = 48
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clk_en_i,
  input  logic               load_i,
  input  logic               abort_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               line_o,
  output logic               oe_o,
  output logic               done_o
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sr_q;
  logic [CNT_W-1:0]   left_q;
  logic               busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
      line_o <= 1'b1;
      oe_o   <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (abort_i) begin
        left_q <= '0;
        busy_q <= 1'b0;
        line_o <= 1'b1;
        oe_o   <= 1'b0;
      end else if (load_i) begin
        sr_q   <= frame_i;
        left_q <= CNT_W'(FRAME_W);
        busy_q <= 1'b1;
      end else if (busy_q && clk_en_i) begin
        if (left_q != '0) begin
          line_o <= sr_q[FRAME_W-1];
          oe_o   <= 1'b1;
          sr_q   <= {sr_q[FRAME_W-2:0], 1'b0};
          left_q <= left_q - 1'b1;
        end else begin
          // end bit has had its full card clock; release the line
          line_o <= 1'b1;
          oe_o   <= 1'b0;
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assert_line_on_ce_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_i && !abort_i) |=> ($stable(line_o) && $stable(oe_o)));
endmodule

// File: rtl/sd_cmd_rx.sv
module sd_cmd_rx
  import sd_cmd_pkg::*;
#(
  parameter int TIMEOUT_CLKS = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_en_i,
  input  logic              arm_i,
  input  logic              long_i,
  input  logic              abort_i,
  input  logic              line_i,
  output logic              done_o,
  output logic              timeout_o,
  output logic [CRC_W-1:0]  crc_o,
  output logic [LONG_W-1:0] frame_o
);
  localparam int CNT_W = $clog2(LONG_W + 1);
  localparam int TW    = $clog2(TIMEOUT_CLKS + 1);

  logic             waiting_q, receiving_q, long_q;
  logic [CNT_W-1:0] cnt_q;
  logic [TW-1:0]    wcnt_q;
  logic [CNT_W-1:0] total;

  assign total = long_q ? CNT_W'(LONG_W) : CNT_W'(SHORT_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      waiting_q   <= 1'b0;
      receiving_q <= 1'b0;
      long_q      <= 1'b0;
      cnt_q       <= '0;
      wcnt_q      <= '0;
      crc_o       <= '0;
      frame_o     <= '0;
      done_o      <= 1'b0;
      timeout_o   <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
      if (abort_i) begin
        waiting_q   <= 1'b0;
        receiving_q <= 1'b0;
      end else if (arm_i) begin
        waiting_q   <= 1'b1;
        receiving_q <= 1'b0;
        long_q      <= long_i;
        cnt_q       <= '0;
        wcnt_q      <= '0;
      end else if (clk_en_i) begin
        if (waiting_q) begin
          if (!line_i) begin
            waiting_q   <= 1'b0;
            receiving_q <= 1'b1;
            frame_o     <= {frame_o[LONG_W-2:0], line_i};
            cnt_q       <= CNT_W'(1);
            crc_o       <= crc7_step('0, line_i);
          end else if (wcnt_q == TW'(TIMEOUT_CLKS - 1)) begin
            waiting_q <= 1'b0;
            timeout_o <= 1'b1;
          end else begin
            wcnt_q <= wcnt_q + 1'b1;
          end
        end else if (receiving_q) begin
          frame_o <= {frame_o[LONG_W-2:0], line_i};
          cnt_q   <= cnt_q + 1'b1;
          if (cnt_q < CNT_W'(CRC_SPAN)) crc_o <= crc7_step(crc_o, line_i);
          if (cnt_q == total - 1'b1) begin
            receiving_q <= 1'b0;
            done_o      <= 1'b1;
          end
        end
      end
    end
  end

  assert_single_outcome_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && timeout_o));
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
  import sd_cmd_pkg::*;
#(
  parameter int TIMEOUT_CLKS = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 card_ce_i,
  input  logic                 cmd_we_i,
  input  logic [CMD_REG_W-1:0] cmd_wdata_i,
  input  logic [ARG_W-1:0]     arg_i,
  input  logic                 clr_we_i,
  input  logic [FLAG_W-1:0]    clr_wdata_i,
  input  logic                 cmd_i,
  output logic                 cmd_o,
  output logic                 cmd_oe_o,
  output logic [FLAG_W:0]      status_o,
  output logic [IDX_W-1:0]     resp_idx_o,
  output logic [31:0]          resp0_o,
  output logic [31:0]          resp1_o,
  output logic [31:0]          resp2_o,
  output logic [31:0]          resp3_o
);
  eng_state_e state_q;
  logic resp_exp_q, long_q, nocrc_q;
  logic start, abort;
  logic [SHORT_W-1:0] frame;
  logic [IDX_W-1:0]   idx;
  logic tx_done, rx_arm, rx_done, rx_tout, crc_ok;
  logic [CRC_W-1:0]  rx_crc;
  logic [LONG_W-1:0] rx_frame;
  logic [FLAG_W-1:0] flags_q, set_vec, clr_mask;
  logic unused_bits;

  assign unused_bits = ^{cmd_wdata_i[9], rx_frame[LONG_W-1:LONG_W-2], rx_frame[0],
                         rx_frame[SHORT_W-1:SHORT_W-2]};

  assign idx   = cmd_wdata_i[IDX_W-1:0];
  assign start = cmd_we_i && cmd_wdata_i[CMD_EN_BIT] && (state_q == ENG_IDLE);
  assign abort = cmd_we_i && !cmd_wdata_i[CMD_EN_BIT] && (state_q != ENG_IDLE);
  assign frame = {1'b0, 1'b1, idx, arg_i, crc7_calc({2'b01, idx, arg_i}), 1'b1};

  sd_cmd_tx #(.FRAME_W(SHORT_W)) i_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clk_en_i (card_ce_i),
    .load_i   (start),
    .abort_i  (abort),
    .frame_i  (frame),
    .line_o   (cmd_o),
    .oe_o     (cmd_oe_o),
    .done_o   (tx_done)
  );

  assign rx_arm = tx_done && resp_exp_q && (state_q == ENG_SEND) && !abort;

  sd_cmd_rx #(.TIMEOUT_CLKS(TIMEOUT_CLKS)) i_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clk_en_i  (card_ce_i),
    .arm_i     (rx_arm),
    .long_i    (long_q),
    .abort_i   (abort),
    .line_i    (cmd_i),
    .done_o    (rx_done),
    .timeout_o (rx_tout),
    .crc_o     (rx_crc),
    .frame_o   (rx_frame)
  );

  // long responses and reserved CRC fields are taken as good
  assign crc_ok = long_q || nocrc_q || (rx_crc == rx_frame[CRC_W:1]);

  always_comb begin
    set_vec = '0;
    if (!abort) begin
      set_vec[FL_SENT]     = (state_q == ENG_SEND) && tx_done && !resp_exp_q;
      set_vec[FL_RESP_END] = (state_q == ENG_RECV) && rx_done && crc_ok;
      set_vec[FL_CRC_FAIL] = (state_q == ENG_RECV) && rx_done && !crc_ok;
      set_vec[FL_TIMEOUT]  = (state_q == ENG_RECV) && rx_tout;
    end
  end

  assign clr_mask = clr_we_i ? clr_wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ENG_IDLE;
      resp_exp_q <= 1'b0;
      long_q     <= 1'b0;
      nocrc_q    <= 1'b0;
      flags_q    <= '0;
    end else begin
      flags_q <= (flags_q & ~clr_mask) | set_vec;
      unique case (state_q)
        ENG_IDLE: if (start) begin
          state_q    <= ENG_SEND;
          resp_exp_q <= cmd_wdata_i[CMD_RESP_BIT];
          long_q     <= cmd_wdata_i[CMD_RESP_BIT] && cmd_wdata_i[CMD_LONG_BIT];
          nocrc_q    <= cmd_wdata_i[CMD_NOCRC_BIT];
        end
        ENG_SEND: begin
          if (abort)        state_q <= ENG_IDLE;
          else if (tx_done) state_q <= resp_exp_q ? ENG_RECV : ENG_IDLE;
        end
        ENG_RECV: if (abort || rx_done || rx_tout) state_q <= ENG_IDLE;
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_idx_o <= '0;
      resp0_o    <= '0;
      resp1_o    <= '0;
      resp2_o    <= '0;
      resp3_o    <= '0;
    end else if ((state_q == ENG_RECV) && rx_done && !abort) begin
      if (long_q) begin
        resp_idx_o <= rx_frame[LONG_W-3 -: IDX_W];
        resp0_o    <= rx_frame[127:96];
        resp1_o    <= rx_frame[95:64];
        resp2_o    <= rx_frame[63:32];
        resp3_o    <= {rx_frame[31:1], 1'b0};
      end else begin
        resp_idx_o <= rx_frame[SHORT_W-3 -: IDX_W];
        resp0_o    <= rx_frame[CRC_W+ARG_W:CRC_W+1];
      end
    end
  end

  assign status_o = {state_q != ENG_IDLE, flags_q};

  assert_busy_after_go_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> status_o[FLAG_W]);
  assert_idle_line_free_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ENG_IDLE) |-> !cmd_oe_o);
  assert_sent_only_noresp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_q[FL_SENT]) |-> !resp_exp_q);
  assert_timeout_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ENG_RECV) && rx_tout && !abort) |=> flags_q[FL_TIMEOUT]);
  assert_clear_works_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && clr_wdata_i[FL_RESP_END] && !set_vec[FL_RESP_END]) |=> !flags_q[FL_RESP_END]);
  assert_abort_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort |=> (!cmd_oe_o && !status_o[FLAG_W]));
endmodule

// File: tb/test_sd_cmd_engine.sv
module test_sd_cmd_engine;
  typedef struct packed {
    logic [5:0]  idx;
    logic [31:0] arg;
    logic        resp;
    logic        nocrc;
    logic [1:0]  mode;   // 0 no reply, 1 good crc, 2 bad crc, 3 silent
    logic [7:0]  delay;
    logic [31:0] pay;
    logic [11:0] exp_st;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{6'd0,  32'h0000_0000, 1'b0, 1'b0, 2'd0, 8'd0,  32'h0,         12'h080}, // R4
    '{6'd8,  32'h0000_01AA, 1'b1, 1'b0, 2'd1, 8'd2,  32'h0000_01AA, 12'h040}, // R5
    '{6'd13, 32'h1234_0000, 1'b1, 1'b0, 2'd2, 8'd5,  32'h0000_0900, 12'h001}, // R6
    '{6'd41, 32'h40FF_8000, 1'b1, 1'b1, 2'd2, 8'd3,  32'h80FF_8000, 12'h040}, // R6 skip
    '{6'd55, 32'h0000_0000, 1'b1, 1'b0, 2'd3, 8'd0,  32'h0,         12'h004}, // R8
    '{6'd17, 32'hFFFF_FFFF, 1'b1, 1'b0, 2'd1, 8'd64, 32'hDEAD_BEEF, 12'h040}, // R8 edge in
    '{6'd24, 32'h0000_0001, 1'b1, 1'b0, 2'd1, 8'd65, 32'h0000_0123, 12'h004}  // R8 edge out
  };

  logic        clk, rst_n, card_ce, cmd_we, clr_we, cmd_line;
  logic [10:0] cmd_wdata, clr_wdata;
  logic [31:0] arg;
  logic        cmd_o, cmd_oe;
  logic [11:0] status;
  logic [5:0]  resp_idx;
  logic [31:0] r0, r1, r2, r3;
  logic [1:0]  ce_div;
  int checks = 0, errors = 0;

  sd_cmd_engine i_sd_cmd_engine (
    .clk_i(clk), .rst_ni(rst_n), .card_ce_i(card_ce), .cmd_we_i(cmd_we),
    .cmd_wdata_i(cmd_wdata), .arg_i(arg), .clr_we_i(clr_we), .clr_wdata_i(clr_wdata),
    .cmd_i(cmd_line), .cmd_o(cmd_o), .cmd_oe_o(cmd_oe), .status_o(status),
    .resp_idx_o(resp_idx), .resp0_o(r0), .resp1_o(r1), .resp2_o(r2), .resp3_o(r3)
  );

  initial clk = 1'b0;
  always #10ns clk = ~clk;

  initial ce_div = 2'd0;
  always @(negedge clk) begin
    ce_div  <= ce_div + 2'd1;
    card_ce <= (ce_div == 2'd3);
  end

  function automatic logic [6:0] tb_crc(input logic [39:0] d);
    logic [6:0] c;
    logic fb;
    c = 7'h0;
    for (int i = 39; i >= 0; i--) begin
      fb = d[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [47:0] tok(input logic [5:0] i, input logic [31:0] a);
    return {2'b01, i, a, tb_crc({2'b01, i, a}), 1'b1};
  endfunction

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic chk(input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic wait_ce();
    @(posedge clk);
    while (!card_ce) @(posedge clk);
    #1ns;
  endtask

  task automatic issue(input logic [5:0] i, input logic [31:0] a,
                       input logic rsp, input logic lng, input logic nocrc);
    @(negedge clk);
    arg       = a;
    cmd_wdata = {1'b1, 1'b0, nocrc, lng, rsp, i};
    cmd_we    = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0;
    chk("R2 busy after go", status[11], 1'b1);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (status[11] && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic clear(input logic [10:0] m);
    @(negedge clk);
    clr_wdata = m;
    clr_we    = 1'b1;
    @(negedge clk);
    clr_we = 1'b0;
  endtask

  task automatic card(input logic [47:0] exp_tok, input logic reply,
                      input logic [135:0] rsp, input int nbits, input int delay);
    logic [47:0] got;
    int guard = 0;
    wait_ce();
    while (!(cmd_oe && cmd_o == 1'b0) && guard < 300) begin
      wait_ce();
      guard++;
    end
    got[47] = cmd_o;
    for (int i = 46; i >= 0; i--) begin
      wait_ce();
      got[i] = cmd_o;
    end
    chk("R3 token", got, exp_tok);
    wait_ce();
    chk("R3 line released after end bit", cmd_oe, 1'b0);
    if (reply) begin
      repeat (delay - 1) wait_ce();
      for (int b = nbits - 1; b >= 0; b--) begin
        cmd_line = rsp[b];
        wait_ce();
      end
      cmd_line = 1'b1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    report();
    $finish;
  end

  initial begin
    logic [135:0] rsp;
    logic [126:0] content;
    rst_n = 1'b0; cmd_we = 1'b0; clr_we = 1'b0; cmd_line = 1'b1;
    cmd_wdata = '0; clr_wdata = '0; arg = '0; card_ce = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", status, 12'h000);
    chk("R1 oe", cmd_oe, 1'b0);
    chk("R1 line", cmd_o, 1'b1);
    chk("R1 resp words", {r0, r1, r2, r3}, 128'h0);
    chk("R1 resp idx", resp_idx, 6'h0);
    // R3 known token for index 0
    chk("R3 index0 token", tok(6'd0, 32'h0), 48'h40_0000_0000_95);

    for (int v = 0; v < NV; v++) begin
      vec_t t;
      logic [6:0] c;
      t = VECS[v];
      c = tb_crc({2'b00, t.idx, t.pay});
      rsp = {88'h0, 2'b00, t.idx, t.pay, (t.mode == 2'd2) ? ~c : c, 1'b1};
      fork
        begin
          issue(t.idx, t.arg, t.resp, 1'b0, t.nocrc);
          wait_idle();
        end
        card(tok(t.idx, t.arg), (t.mode == 2'd1 || t.mode == 2'd2), rsp, 48, int'(t.delay));
      join
      @(negedge clk);
      chk($sformatf("R4 R5 R6 R8 status vec%0d", v), status, t.exp_st);
      if (t.mode == 2'd1 || t.mode == 2'd2) begin
        if (t.exp_st != 12'h004) begin
          chk($sformatf("R5 payload vec%0d", v), r0, t.pay);
          chk($sformatf("R5 index vec%0d", v), resp_idx, t.idx);
        end
      end
      @(negedge clk);
      cmd_wdata = '0; cmd_we = 1'b1;
      @(negedge clk);
      cmd_we = 1'b0;
      clear(11'h7FF);
      chk($sformatf("R9 clear all vec%0d", v), status, 12'h000);
    end

    // R7 long response
    content = {31'h1234567, 32'h89AB_CDEF, 32'h0F1E_2D3C, 32'h4B5A_6978};
    rsp = {2'b00, 6'h3F, content, 1'b1};
    fork
      begin
        issue(6'd2, 32'h0, 1'b1, 1'b1, 1'b0);
        wait_idle();
      end
      card(tok(6'd2, 32'h0), 1'b1, rsp, 136, 4);
    join
    @(negedge clk);
    chk("R7 status", status, 12'h040);
    chk("R7 words", {r0, r1, r2, r3}, {content, 1'b0});
    chk("R7 index", resp_idx, 6'h3F);
    clear(11'h7FF);

    // R9 sticky flags and partial clear
    fork
      begin
        issue(6'd0, 32'h0, 1'b0, 1'b0, 1'b0);
        wait_idle();
      end
      card(tok(6'd0, 32'h0), 1'b0, '0, 48, 1);
    join
    rsp = {88'h0, 2'b00, 6'd9, 32'h0000_0A5A, tb_crc({2'b00, 6'd9, 32'h0000_0A5A}), 1'b1};
    fork
      begin
        issue(6'd9, 32'h0001_0000, 1'b1, 1'b0, 1'b0);
        wait_idle();
      end
      card(tok(6'd9, 32'h0001_0000), 1'b1, rsp, 48, 2);
    join
    @(negedge clk);
    chk("R9 sticky", status, 12'h0C0);
    clear(11'h040);
    chk("R9 partial clear", status, 12'h080);
    clear(11'h080);
    chk("R9 last clear", status, 12'h000);

    // R10 abort in the middle of a token
    issue(6'd7, 32'hCAFE_0000, 1'b1, 1'b0, 1'b0);
    repeat (60) @(negedge clk);
    chk("R10 driving before abort", cmd_oe, 1'b1);
    cmd_wdata = '0; cmd_we = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0;
    chk("R10 line released", {cmd_oe, cmd_o}, 2'b01);
    chk("R10 busy dropped", status[11], 1'b0);
    repeat (400) @(negedge clk);
    chk("R10 no flags", status, 12'h000);

    report();
    $finish;
  end
endmodule